// File: doc/BRIEF.md
# Request-Response Timeout Watchdog

This block watches a timing rule between two single-bit signals: once a request rises, a response must follow within a bounded number of clock cycles. A rising edge on the request arms the watchdog and loads a countdown of `WINDOW` cycles. If the response arrives while the countdown is running, the watchdog reports a kick and goes back to idle. If the countdown runs out first, the watchdog bites.

A bite is reported with the severity chosen on a select input. A warning raises only the bite pulse. An error or a stop also raises a dedicated pulse. Every arming ends in exactly one outcome, so the checker can never wait forever. After either outcome the block waits for the next request edge. An enable input switches the whole check off.

Top module: `req_rsp_watchdog`

## Requirements
- R1: A synchronous active-high reset returns the block to idle, and all four outputs read 0 in the cycle after reset.
- R2: A request rising at clock edge N arms the watchdog. A response sampled high at any edge N+1 to N+WINDOW makes `kick_o` high for the cycle after that edge, and no bite follows for that arming.
- R3: Each arming produces exactly one outcome. After a kick or a bite, no further kick or bite appears until a new request rising edge.
- R4: A response sampled at edge N+WINDOW, the last edge of the window where the count would expire, counts as a kick and not as a bite.
- R5: If no response is sampled at edges N+1 to N+WINDOW, `bite_o` is high for the cycle after edge N+WINDOW and is low before it.
- R6: The severity is sampled at the bite edge. With `sev`=2'b00 (warning) only `bite_o` rises. With 2'b01 (error), `err_o` pulses together with `bite_o`. With 2'b10 or 2'b11 (stop), `stop_o` pulses together with `bite_o`.
- R7: After a bite the block is idle, and the next request rising edge arms a new, independent check.
- R8: While `en` is low the block neither arms nor bites. Dropping `en` during a window cancels that window with no outcome.
- R9: Arming needs a rising edge of `req`. A request held high after its window has ended does not arm again.
- R10: A request rising edge while the block is already armed is ignored and does not restart the window.
- R11: `kick_o`, `bite_o`, `err_o` and `stop_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Check enable |
| req | input | 1 | Request; its rising edge arms the check |
| rsp | input | 1 | Response; kicks the watchdog while armed |
| sev | input | 2 | Bite severity: 00 warning, 01 error, 1x stop |
| kick_o | output | 1 | Pulse: response arrived inside the window |
| bite_o | output | 1 | Pulse: window expired without a response |
| err_o | output | 1 | Pulse: bite with error severity |
| stop_o | output | 1 | Pulse: bite with stop severity |

## Verification
The bench builds the block with the default window of 4 cycles. With this window every response position can be tried one by one, including the first and last edges and the edge just past the window. The short window also makes it cheap to show that a second request edge mid-window does not extend the deadline, because a restarted window would bite at a later, distinct cycle. Back-to-back passing and failing checks, all three severities, a held request and disabling mid-window are each driven as separate scenarios.

// File: rtl/req_rsp_watchdog.sv
module req_rsp_watchdog #(
  parameter int WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       req,
  input  logic       rsp,
  input  logic [1:0] sev,
  output logic       kick_o,
  output logic       bite_o,
  output logic       err_o,
  output logic       stop_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LOAD = CW'(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic          req_q;
  logic          armed;
  logic [CW-1:0] cnt;

  logic rise, hit, expire;
  assign rise   = req & ~req_q;
  assign hit    = armed & en & rsp;
  assign expire = armed & en & ~rsp & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
      kick_o <= 1'b0;
      bite_o <= 1'b0;
      err_o  <= 1'b0;
      stop_o <= 1'b0;
    end else begin
      req_q  <= req;
      kick_o <= hit;
      bite_o <= expire;
      err_o  <= expire & (sev == 2'b01);
      stop_o <= expire & sev[1];
      if (!en) begin
        armed <= 1'b0;
      end else if (armed) begin
        if (rsp || cnt == LAST) armed <= 1'b0;
        else cnt <= cnt - LAST;
      end else if (rise) begin
        armed <= 1'b1;
        cnt   <= LOAD;
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !kick_o && !bite_o && !err_o && !stop_o);

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    !(kick_o && bite_o));

  // R5
  bite_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (kick_o || bite_o) |-> $past(armed));

  // R6
  sev_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o || stop_o) |-> (bite_o && !(err_o && stop_o)));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !kick_o && !bite_o);

  // R11
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (kick_o || bite_o) |=> !kick_o && !bite_o);
endmodule

// File: tb/tb_req_rsp_watchdog.sv
module tb_req_rsp_watchdog;
  logic clk = 1'b0;
  logic rst, en, req, rsp;
  logic [1:0] sev;
  logic kick_o, bite_o, err_o, stop_o;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  req_rsp_watchdog #(.WINDOW(4)) dut (
    .clk(clk), .rst(rst), .en(en), .req(req), .rsp(rsp), .sev(sev),
    .kick_o(kick_o), .bite_o(bite_o), .err_o(err_o), .stop_o(stop_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {kick_o, bite_o, err_o, stop_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {kick,bite,err,stop} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic quiet(string tag, int n);
    for (int i = 0; i < n; i++) begin
      tick();
      check(tag, 4'b0000);
    end
  endtask

  task automatic idle_gap();
    req = 0; rsp = 0;
    tick(); tick();
  endtask

  task automatic t_reset();
    rst = 1; en = 1; req = 0; rsp = 0; sev = 2'b00;
    tick(); tick();
    rst = 0;
    check("R1 reset", 4'b0000);
  endtask

  task automatic t_kick_at(int k, string tag);
    req = 1; tick();
    for (int i = 1; i <= 4; i++) begin
      rsp = (i == k);
      tick();
      if (i == k) check(tag, 4'b1000);
      else if (i < k) check(tag, 4'b0000);
    end
    rsp = 0; tick();
    check("R11 kick pulse", 4'b0000);
    quiet("R3 no bite after kick", 5);
    idle_gap();
  endtask

  task automatic t_bite(logic [1:0] s, logic [3:0] exp, string tag);
    sev = s; req = 1; tick();
    req = 0;
    for (int i = 1; i <= 3; i++) begin tick(); check("R5 no early bite", 4'b0000); end
    tick(); check(tag, exp);
    tick(); check("R11 bite pulse", 4'b0000);
    quiet("R3 no outcome after bite", 4);
    sev = 2'b00;
    idle_gap();
  endtask

  task automatic t_rearm();
    t_bite(2'b00, 4'b0100, "R7 first check bites");
    req = 1; tick();
    rsp = 1; tick(); check("R7 second check kicks", 4'b1000);
    rsp = 0;
    idle_gap();
  endtask

  task automatic t_disabled();
    en = 0; req = 1; tick();
    req = 0;
    quiet("R8 disabled no arm", 6);
    en = 1; tick();
    req = 1; tick();
    req = 0; tick(); tick();
    en = 0;
    quiet("R8 disable mid-window", 5);
    en = 1;
    idle_gap();
  endtask

  task automatic t_held();
    req = 1; tick();
    tick(); tick(); tick();
    tick(); check("R9 first bite", 4'b0100);
    quiet("R9 held req no rearm", 8);
    idle_gap();
  endtask

  task automatic t_rearm_ignored();
    req = 1; tick();
    req = 0; tick(); check("R10 cycle1", 4'b0000);
    req = 1; tick(); check("R10 cycle2", 4'b0000);
    tick(); check("R10 cycle3", 4'b0000);
    tick(); check("R10 bite on original deadline", 4'b0100);
    quiet("R10 window not restarted", 4);
    idle_gap();
  endtask

  initial begin
    #(20 * 5000);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_kick_at(1, "R2 kick first edge");
    t_kick_at(2, "R2 kick mid window");
    t_kick_at(4, "R4 kick at expiry edge");
    t_bite(2'b00, 4'b0100, "R5 R6 warning bite");
    t_bite(2'b01, 4'b0110, "R6 error bite");
    t_bite(2'b10, 4'b0101, "R6 stop bite");
    t_bite(2'b11, 4'b0101, "R6 stop bite 11");
    t_rearm();
    t_disabled();
    t_held();
    t_rearm_ignored();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule